// File: doc/BRIEF.md
# Interrupt Pin Event Dispatcher

This block turns per-pin assert and deassert events into interrupt messages. It keeps a saturating assertion count for each of its pins. A message is attempted only when a count leaves zero. Each pin's configuration entry is supplied from outside as a flat input vector, and the block decides what to send from it: the mask, the trigger mode, the vector, the destination, the destination mode and the delivery mode.

For level-triggered pins the block holds a remote-IRR bit. While the bit is set, further messages from that pin are suppressed. An end-of-interrupt that carries a vector clears the bit on every pin whose entry matches that vector, scanning the pins one per cycle in ascending order. A pin whose count is still non-zero at that point is sent again. When software rewrites a pin's entry, it pulses a write notification, and the block re-evaluates that pin at once.

There are three request inputs, and one arbiter serves them. Only one action is taken per cycle. Messages leave through a registered valid/ready port, and a counter records each completed handshake.

Top module: `irq_event_dispatcher`

## Requirements
- R1: Each pin has an 8-bit assertion count. An assert at 255 leaves it at 255 and pulses `sat_hi`. A deassert at 0 leaves it at 0 and pulses `sat_lo`. Each pulse lasts one cycle, appears in the cycle after the event is accepted, and comes with `sat_pin`.
- R2: A pin event produces a message attempt only when it moves that pin's count from 0 to 1. No other count change produces a message.
- R3: `pin_op` encodes 0 = assert, 1 = deassert, 2 = pulse. A pulse acts as an assert followed by a deassert. If the assert saturates, the deassert is skipped.
- R4: An attempt on a pin whose entry has bit 16 (mask) set produces no message and leaves that pin's remote IRR unchanged.
- R5: Entry bit 15 set means level-triggered. An attempt on an unmasked level pin is suppressed if its remote IRR is set; otherwise it sends and sets remote IRR. An edge-triggered pin never sets remote IRR.
- R6: An accepted EOI scans pins 0 to NPINS-1 over the next NPINS cycles, one pin per cycle. A pin with remote IRR set and entry bits [7:0] equal to the EOI vector has remote IRR cleared, and it is sent again if its count is non-zero. `eoi_ready` stays low during the scan.
- R7: On a write notification for a pin, if the entry is edge-triggered, remote IRR is cleared with no message. If the entry is level-triggered and the count is non-zero, a message attempt is made under the rules of R4 and R5.
- R8: A message carries the vector from entry bits [7:0], the delivery mode from [10:8], and the destination from [63:56]. `msg_phys` is the inverse of entry bit 11, and `msg_level` is entry bit 15. It appears on the output in the cycle after the triggering action is accepted.
- R9: The arbiter takes one action per cycle, in the priority EOI scan step, then EOI accept, then write notification, then pin event. No request is accepted, and a presented message holds stable, while `msg_valid` is high and `msg_ready` is low.
- R10: `msg_count` increases by one on each cycle with `msg_valid` and `msg_ready` both high, and at no other time.
- R11: After reset, all counts and remote-IRR bits are zero, no message is presented, `msg_count` is zero, and all three ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_table | input | NPINS*64 | Configuration entries; pin i occupies bits [64*i+63:64*i] |
| pin_valid | input | 1 | Pin event request |
| pin_ready | output | 1 | Pin event accepted this cycle when valid |
| pin_idx | input | PW | Pin addressed by the event |
| pin_op | input | 2 | 0 assert, 1 deassert, 2 pulse |
| wr_valid | input | 1 | Entry-rewritten notification |
| wr_ready | output | 1 | Notification accepted when valid |
| wr_pin | input | PW | Pin whose entry was rewritten |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | EOI accepted when valid; low during a scan |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Downstream takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_phys | output | 1 | 1 = physical destination, 0 = logical |
| msg_dmode | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 = level-triggered source |
| msg_count | output | 32 | Completed message handshakes |
| rirr_o | output | NPINS | Remote-IRR bit of each pin |
| sat_hi | output | 1 | High saturation seen on the last accepted event |
| sat_lo | output | 1 | Low saturation seen on the last accepted event |
| sat_pin | output | PW | Pin of the saturation pulse |

## Verification
The assertions assume that the environment keeps each request's valid and payload steady until the matching ready is seen. They also assume `entry_table` changes only between actions, and that any change to a pin's entry is followed by a write notification for that pin before the entry matters again. The stimulus meets this by driving every input on the falling edge, holding it until acceptance, and changing an entry only immediately before the write notification that announces it. `msg_ready` is held high except in one deliberate stall window, and outside that window every message is taken on the cycle it appears.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int ENTRY_W = 64;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;

  typedef enum logic [1:0] {
    OP_ASSERT   = 2'd0,
    OP_DEASSERT = 2'd1,
    OP_PULSE    = 2'd2,
    OP_NONE     = 2'd3
  } pin_op_e;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_PIN   = 2'd1,
    ACT_WRITE = 2'd2,
    ACT_SCAN  = 2'd3
  } act_kind_e;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic               mask;
    logic               level;
    logic               logical;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vector;
  } entry_t;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DEST_W-1:0]  dest;
    logic               phys;
    logic [DMODE_W-1:0] dmode;
    logic               level;
  } msg_t;

  // Field positions are fixed: a neighbouring register file lays entries out this way.
  function automatic entry_t decode_entry(input logic [ENTRY_W-1:0] raw);
    entry_t e;
    e.vector  = raw[7:0];
    e.dmode   = raw[10:8];
    e.logical = raw[11];
    e.level   = raw[15];
    e.mask    = raw[16];
    e.dest    = raw[63:56];
    return e;
  endfunction

  function automatic msg_t build_msg(input entry_t e);
    msg_t m;
    m.vector = e.vector;
    m.dest   = e.dest;
    m.phys   = ~e.logical;
    m.dmode  = e.dmode;
    m.level  = e.level;
    return m;
  endfunction

endpackage

// File: rtl/irqd_pin_counters.sv
module irqd_pin_counters
  import irqd_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CNT_W = 8,
  localparam int PW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PW-1:0]    pin,
  input  pin_op_e          op,
  output logic             rise,
  output logic             sat_hi,
  output logic             sat_lo,
  output logic [NPINS-1:0] nonzero
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  typedef struct packed {
    logic [CNT_W-1:0] next;
    logic             hi;
    logic             lo;
    logic             up;
  } step_t;

  // Saturating count update; a pulse nets to zero unless the assert half saturates.
  function automatic step_t count_step(input logic [CNT_W-1:0] cur, input pin_op_e o);
    step_t s;
    s.next = cur;
    s.hi   = 1'b0;
    s.lo   = 1'b0;
    s.up   = 1'b0;
    case (o)
      OP_ASSERT: begin
        if (cur == CMAX) s.hi = 1'b1;
        else             s.next = cur + 1'b1;
        s.up = (cur == '0);
      end
      OP_DEASSERT: begin
        if (cur == '0) s.lo = 1'b1;
        else           s.next = cur - 1'b1;
      end
      OP_PULSE: begin
        if (cur == CMAX) s.hi = 1'b1;
        s.up = (cur == '0);
      end
      default: ;
    endcase
    return s;
  endfunction

  logic [CNT_W-1:0] cnt_q [NPINS];
  logic [CNT_W-1:0] cur;
  step_t            st;

  assign cur    = cnt_q[pin];
  assign st     = count_step(cur, op);
  assign rise   = en & st.up;
  assign sat_hi = en & st.hi;
  assign sat_lo = en & st.lo;

  for (genvar i = 0; i < NPINS; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_q[i] <= '0;
      else if (en && (pin == PW'(i)))     cnt_q[i] <= st.next;
    end
    assign nonzero[i] = |cnt_q[i];
  end

endmodule

// File: rtl/irqd_rirr_bank.sv
module irqd_rirr_bank #(
  parameter int NPINS = 32,
  localparam int PW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    idx,
  input  logic             set_en,
  input  logic             clr_en,
  output logic [NPINS-1:0] rirr
);

  // Set wins over clear: an EOI that clears and immediately re-sends ends set.
  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                          rirr[i] <= 1'b0;
      else if (idx == PW'(i)) begin
        if (set_en)      rirr[i] <= 1'b1;
        else if (clr_en) rirr[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqd_sequencer.sv
module irqd_sequencer
  import irqd_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int PW   = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             can_go,
  input  logic             pin_valid,
  input  logic [PW-1:0]    pin_idx,
  output logic             pin_ready,
  input  logic             wr_valid,
  input  logic [PW-1:0]    wr_pin,
  output logic             wr_ready,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             eoi_ready,
  output act_kind_e        kind,
  output logic [PW-1:0]    act_pin,
  output logic [VEC_W-1:0] scan_vec,
  output logic             scan_busy
);

  localparam logic [PW-1:0] LAST_PIN = PW'(NPINS - 1);

  logic [PW-1:0] scan_ptr;
  logic          eoi_take;

  assign eoi_ready = can_go & ~scan_busy;
  assign wr_ready  = eoi_ready & ~eoi_valid;
  assign pin_ready = wr_ready & ~wr_valid;
  assign eoi_take  = eoi_valid & eoi_ready;

  always_comb begin
    kind    = ACT_IDLE;
    act_pin = pin_idx;
    if (scan_busy && can_go) begin
      kind    = ACT_SCAN;
      act_pin = scan_ptr;
    end else if (wr_valid && wr_ready) begin
      kind    = ACT_WRITE;
      act_pin = wr_pin;
    end else if (pin_valid && pin_ready) begin
      kind    = ACT_PIN;
      act_pin = pin_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_busy <= 1'b0;
      scan_ptr  <= '0;
      scan_vec  <= '0;
    end else if (eoi_take) begin
      scan_busy <= 1'b1;
      scan_ptr  <= '0;
      scan_vec  <= eoi_vector;
    end else if (kind == ACT_SCAN) begin
      if (scan_ptr == LAST_PIN) scan_busy <= 1'b0;
      else                      scan_ptr  <= scan_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/irqd_msg_out.sv
module irqd_msg_out
  import irqd_pkg::*;
#(
  parameter int MCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  msg_t              msg_in,
  input  logic              msg_ready,
  output logic              msg_valid,
  output msg_t              msg_q,
  output logic              can_go,
  output logic [MCNT_W-1:0] msg_count
);

  assign can_go = ~msg_valid | msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_q     <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_q     <= msg_in;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      msg_count <= '0;
    else if (msg_valid && msg_ready) msg_count <= msg_count + 1'b1;
  end

endmodule

// File: rtl/irq_event_dispatcher.sv
module irq_event_dispatcher
  import irqd_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 8,
  parameter int MCNT_W = 32,
  localparam int PW    = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS*ENTRY_W-1:0] entry_table,
  input  logic                     pin_valid,
  output logic                     pin_ready,
  input  logic [PW-1:0]            pin_idx,
  input  logic [1:0]               pin_op,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [PW-1:0]            wr_pin,
  input  logic                     eoi_valid,
  output logic                     eoi_ready,
  input  logic [VEC_W-1:0]         eoi_vector,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [VEC_W-1:0]         msg_vector,
  output logic [DEST_W-1:0]        msg_dest,
  output logic                     msg_phys,
  output logic [DMODE_W-1:0]       msg_dmode,
  output logic                     msg_level,
  output logic [MCNT_W-1:0]        msg_count,
  output logic [NPINS-1:0]         rirr_o,
  output logic                     sat_hi,
  output logic                     sat_lo,
  output logic [PW-1:0]            sat_pin
);

  act_kind_e        kind;
  logic [PW-1:0]    act_pin;
  logic [VEC_W-1:0] scan_vec;
  logic             scan_busy;
  logic             can_go;
  entry_t           ent;
  msg_t             msg_q;

  logic             cnt_en, cnt_rise, cnt_hi, cnt_lo;
  logic [NPINS-1:0] nonzero;
  logic             cur_rirr, cur_nz;

  // Named internal events, shared with the checker.
  logic             scan_match;
  logic             wr_edge;
  logic             attempt;
  logic             rirr_eff;
  logic             fire;
  logic             rirr_set;
  logic             rirr_clr;

  irqd_sequencer #(.NPINS(NPINS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .can_go     (can_go),
    .pin_valid  (pin_valid),
    .pin_idx    (pin_idx),
    .pin_ready  (pin_ready),
    .wr_valid   (wr_valid),
    .wr_pin     (wr_pin),
    .wr_ready   (wr_ready),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .eoi_ready  (eoi_ready),
    .kind       (kind),
    .act_pin    (act_pin),
    .scan_vec   (scan_vec),
    .scan_busy  (scan_busy)
  );

  assign ent    = decode_entry(entry_table[act_pin*ENTRY_W +: ENTRY_W]);
  assign cnt_en = (kind == ACT_PIN);

  irqd_pin_counters #(.NPINS(NPINS), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .pin     (act_pin),
    .op      (pin_op_e'(pin_op)),
    .rise    (cnt_rise),
    .sat_hi  (cnt_hi),
    .sat_lo  (cnt_lo),
    .nonzero (nonzero)
  );

  assign cur_rirr = rirr_o[act_pin];
  assign cur_nz   = nonzero[act_pin];

  // Clearing happens ahead of the delivery decision in the same action.
  assign scan_match = (kind == ACT_SCAN) & cur_rirr & (ent.vector == scan_vec);
  assign wr_edge    = (kind == ACT_WRITE) & ~ent.level;
  assign attempt    = ((kind == ACT_PIN) & cnt_rise)
                    | ((kind == ACT_WRITE) & ent.level & cur_nz)
                    | (scan_match & cur_nz);
  assign rirr_eff   = cur_rirr & ~scan_match & ~wr_edge;
  assign fire       = attempt & ~ent.mask & (~ent.level | ~rirr_eff);
  assign rirr_set   = fire & ent.level;
  assign rirr_clr   = scan_match | wr_edge;

  irqd_rirr_bank #(.NPINS(NPINS)) u_rirr (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (act_pin),
    .set_en (rirr_set),
    .clr_en (rirr_clr),
    .rirr   (rirr_o)
  );

  irqd_msg_out #(.MCNT_W(MCNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .msg_in    (build_msg(ent)),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_q     (msg_q),
    .can_go    (can_go),
    .msg_count (msg_count)
  );

  assign msg_vector = msg_q.vector;
  assign msg_dest   = msg_q.dest;
  assign msg_phys   = msg_q.phys;
  assign msg_dmode  = msg_q.dmode;
  assign msg_level  = msg_q.level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sat_hi  <= 1'b0;
      sat_lo  <= 1'b0;
      sat_pin <= '0;
    end else begin
      sat_hi  <= cnt_hi;
      sat_lo  <= cnt_lo;
      sat_pin <= act_pin;
    end
  end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int NPINS  = 32,
  parameter int MCNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [7:0]        msg_dest,
  input logic [MCNT_W-1:0] msg_count,
  input logic              eoi_ready,
  input logic              wr_ready,
  input logic              pin_ready,
  input logic              scan_busy,
  input logic [1:0]        kind,
  input logic              fire,
  input logic              act_mask,
  input logic              rirr_set,
  input logic [NPINS-1:0]  rirr,
  input logic              sat_hi,
  input logic              sat_lo
);

  // R9: a stalled message holds its contents.
  a_r9_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

  // R9: nothing is accepted while the output is blocked.
  a_r9_stall_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |-> !eoi_ready && !wr_ready && !pin_ready);

  // R10: one count per handshake.
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> msg_count == $past(msg_count) + 1'b1);

  a_r10_count_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready) |=> $stable(msg_count));

  // R6: no new EOI while a scan runs.
  a_r6_eoi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !eoi_ready);

  // R4: a masked entry never loads a message.
  a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    act_mask && kind != 2'd0 |-> !fire);

  // R5: remote IRR only rises after a level delivery.
  a_r5_rirr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rirr & ~$past(rirr))) |-> $past(rirr_set));

  // R1: a single event cannot saturate both ways.
  a_r1_sat_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi && sat_lo));

  // R8: a new message appears only after an action fired.
  a_r8_msg_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(fire));

endmodule

bind irq_event_dispatcher irqd_checker #(.NPINS(NPINS), .MCNT_W(MCNT_W)) u_irqd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_dest   (msg_dest),
  .msg_count  (msg_count),
  .eoi_ready  (eoi_ready),
  .wr_ready   (wr_ready),
  .pin_ready  (pin_ready),
  .scan_busy  (scan_busy),
  .kind       (kind),
  .fire       (fire),
  .act_mask   (ent.mask),
  .rirr_set   (rirr_set),
  .rirr       (rirr_o),
  .sat_hi     (sat_hi),
  .sat_lo     (sat_lo)
);

// File: tb/test_irq_event_dispatcher.sv
module test_irq_event_dispatcher;

  localparam int NP = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*64-1:0] tbl;
  logic            pin_valid = 0, wr_valid = 0, eoi_valid = 0, msg_ready = 1;
  logic [4:0]      pin_idx = 0, wr_pin = 0;
  logic [1:0]      pin_op = 0;
  logic [7:0]      eoi_vector = 0;
  logic            pin_ready, wr_ready, eoi_ready, msg_valid, msg_phys, msg_level;
  logic [7:0]      msg_vector, msg_dest;
  logic [2:0]      msg_dmode;
  logic [31:0]     msg_count;
  logic [NP-1:0]   rirr_o;
  logic            sat_hi, sat_lo;
  logic [4:0]      sat_pin;

  always #2 clk = ~clk;

  irq_event_dispatcher i_irq_event_dispatcher (
    .clk(clk), .rst_n(rst_n), .entry_table(tbl),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_idx(pin_idx), .pin_op(pin_op),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_pin(wr_pin),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_phys(msg_phys), .msg_dmode(msg_dmode),
    .msg_level(msg_level), .msg_count(msg_count), .rirr_o(rirr_o),
    .sat_hi(sat_hi), .sat_lo(sat_lo), .sat_pin(sat_pin)
  );

  logic [63:0] ent [NP];
  int          mcnt [NP];
  logic [NP-1:0] mrirr;
  int          n_chk = 0, n_fail = 0, exp_count = 0;

  always_comb for (int i = 0; i < NP; i++) tbl[i*64 +: 64] = ent[i];

  function automatic logic [63:0] mk(input int vec, input int dm, input bit logical,
                                     input bit lvl, input bit msk, input int dst);
    logic [63:0] r = '0;
    r[7:0] = vec[7:0]; r[10:8] = dm[2:0]; r[11] = logical;
    r[15] = lvl; r[16] = msk; r[63:56] = dst[7:0];
    return r;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of a delivery attempt (R4, R5).
  function automatic bit m_send(input int p);
    if (ent[p][16]) return 1'b0;
    if (ent[p][15]) begin
      if (mrirr[p]) return 1'b0;
      mrirr[p] = 1'b1;
    end
    return 1'b1;
  endfunction

  task automatic chk_msg(input string tag, input int p, input bit f);
    chk({tag, " msg_valid"}, msg_valid, f);
    if (f && msg_valid) begin
      chk({tag, " R8 vector"}, msg_vector, ent[p][7:0]);
      chk({tag, " R8 dest"},   msg_dest,   ent[p][63:56]);
      chk({tag, " R8 phys"},   msg_phys,   !ent[p][11]);
      chk({tag, " R8 dmode"},  msg_dmode,  ent[p][10:8]);
      chk({tag, " R8 level"},  msg_level,  ent[p][15]);
    end
    if (f) exp_count++;
    chk({tag, " R5 rirr"}, rirr_o, mrirr);
  endtask

  task automatic do_pin(input int p, input int op, input string tag);
    bit hi = 0, lo = 0, f = 0, acc;
    int old = mcnt[p];
    case (op)
      0: begin if (old == 255) hi = 1; else mcnt[p]++; if (old == 0) f = m_send(p); end
      1: begin if (old == 0) lo = 1; else mcnt[p]--; end
      default: begin if (old == 255) hi = 1; else if (old == 0) f = m_send(p); end
    endcase
    @(negedge clk);
    pin_valid = 1; pin_idx = p[4:0]; pin_op = op[1:0];
    forever begin #1; acc = pin_ready; @(posedge clk); if (acc) break; end
    @(negedge clk);
    pin_valid = 0;
    chk_msg(tag, p, f);
    chk({tag, " R1 sat_hi"}, sat_hi, hi);
    chk({tag, " R1 sat_lo"}, sat_lo, lo);
    if (hi || lo) chk({tag, " R1 sat_pin"}, sat_pin, p);
  endtask

  task automatic do_wr(input int p, input string tag);
    bit f = 0, acc;
    if (!ent[p][15]) mrirr[p] = 1'b0;
    else if (mcnt[p] > 0) f = m_send(p);
    @(negedge clk);
    wr_valid = 1; wr_pin = p[4:0];
    forever begin #1; acc = wr_ready; @(posedge clk); if (acc) break; end
    @(negedge clk);
    wr_valid = 0;
    chk_msg(tag, p, f);
  endtask

  task automatic do_eoi(input int vec, input string tag);
    bit acc;
    @(negedge clk);
    eoi_valid = 1; eoi_vector = vec[7:0];
    forever begin #1; acc = eoi_ready; @(posedge clk); if (acc) break; end
    @(negedge clk);
    eoi_valid = 0;
    chk({tag, " R6 busy"}, eoi_ready, 0);
    for (int k = 0; k < NP; k++) begin
      bit f = 0;
      if (mrirr[k] && ent[k][7:0] == vec[7:0]) begin
        mrirr[k] = 1'b0;
        if (mcnt[k] > 0) f = m_send(k);
      end
      @(negedge clk);
      chk_msg({tag, " R6 scan"}, k, f);
    end
    chk({tag, " R6 done"}, eoi_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      ent[i] = mk(32 + i, i % 8, i[0], 0, 0, (i * 37) % 256);
      mcnt[i] = 0;
    end
    mrirr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 msg_valid", msg_valid, 0);
    chk("R11 rirr", rirr_o, 0);
    chk("R11 count", msg_count, 0);
    chk("R11 readies", {eoi_ready, wr_ready, pin_ready}, 3'b111);

    // R2 R8: first assert of every pin sends, second does not
    for (int p = 0; p < NP; p++) do_pin(p, 0, "R2 first");
    for (int p = 0; p < NP; p++) do_pin(p, 0, "R2 second");
    for (int p = 0; p < NP; p++) begin do_pin(p, 1, "R2 drop"); do_pin(p, 1, "R2 drop0"); end
    // R3: pulse from zero sends and returns to zero
    for (int p = 0; p < NP; p++) do_pin(p, 2, "R3 pulse");
    for (int p = 0; p < NP; p++) do_pin(p, 2, "R3 pulse again");

    // R4: masked level pin
    ent[3] = mk(8'h43, 1, 0, 1, 1, 8'h11); do_wr(3, "R4 cfg");
    do_pin(3, 0, "R4 masked assert");
    do_pin(3, 1, "R4 masked drop");
    ent[4] = mk(8'h44, 0, 0, 1, 0, 8'h22); do_wr(4, "R4 cfg4");
    do_pin(4, 0, "R4 level send");
    do_pin(4, 1, "R4 drop");
    ent[4] = mk(8'h44, 0, 0, 1, 1, 8'h22); do_wr(4, "R4 mask4");
    do_pin(4, 0, "R4 masked keeps rirr");

    // R5 R6: level pin handshake
    ent[5] = mk(8'h55, 2, 1, 1, 0, 8'h33); do_wr(5, "R5 cfg");
    do_pin(5, 0, "R5 level send");
    do_pin(5, 1, "R5 drop");
    do_pin(5, 0, "R5 suppressed");
    do_eoi(8'h55, "R6 resend");
    do_pin(5, 1, "R6 drop");
    do_eoi(8'h55, "R6 no resend");
    do_eoi(8'h44, "R6 masked clear");

    // R6: several pins share one vector, ascending order
    for (int p = 8; p <= 10; p++) begin
      ent[p] = mk(8'h77, p % 8, 0, 1, 0, p); do_wr(p, "R6 cfg"); do_pin(p, 0, "R6 arm");
    end
    ent[11] = mk(8'h77, 0, 0, 0, 0, 11); do_wr(11, "R7 cfg edge");
    do_pin(11, 0, "R5 edge no rirr");
    do_eoi(8'h77, "R6 multi");
    do_eoi(8'h99, "R6 nomatch");

    // R7: write notification
    ent[12] = mk(8'h5C, 4, 0, 1, 0, 8'hC0); do_wr(12, "R7 cfg");
    do_pin(12, 0, "R7 arm");
    ent[12] = mk(8'h5C, 4, 0, 0, 0, 8'hC0); do_wr(12, "R7 to edge");
    ent[12] = mk(8'h5C, 4, 0, 1, 0, 8'hC0); do_wr(12, "R7 to level");
    do_wr(12, "R7 rewrite suppressed");

    // R1 R3: saturation
    for (int i = 0; i < 255; i++) do_pin(20, 0, "R1 climb");
    do_pin(20, 0, "R1 sat high");
    do_pin(20, 2, "R3 pulse at max");
    for (int i = 0; i < 255; i++) do_pin(20, 1, "R1 descend");
    do_pin(20, 1, "R1 sat low");
    do_pin(20, 0, "R1 restart");
    do_pin(21, 1, "R1 sat low fresh");

    // R9: priority
    @(negedge clk);
    eoi_valid = 1; eoi_vector = 8'hEE; wr_valid = 1; wr_pin = 5'd1; pin_valid = 1; pin_idx = 5'd2;
    #1;
    chk("R9 prio eoi", {eoi_ready, wr_ready, pin_ready}, 3'b100);
    eoi_valid = 0;
    #0.5;
    chk("R9 prio wr", {wr_ready, pin_ready}, 2'b10);
    wr_valid = 0; pin_valid = 0;

    // R9: stall
    @(negedge clk);
    msg_ready = 0;
    do_pin(24, 0, "R9 stall first");
    @(negedge clk);
    pin_valid = 1; pin_idx = 5'd25; pin_op = 2'd0;
    #1;
    chk("R9 stalled ready", pin_ready, 0);
    repeat (3) @(negedge clk);
    chk("R9 held", msg_vector, ent[24][7:0]);
    chk("R10 no handshake", msg_count, exp_count - 1);
    msg_ready = 1;
    @(negedge clk);
    pin_valid = 0;
    mcnt[25] = 1;
    chk_msg("R9 after stall", 25, 1);
    @(negedge clk);
    chk("R10 count", msg_count, exp_count);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule